// File: doc/BRIEF.md
# Fault Recovery Hold Timer

This block supervises a power output stage. A fault input pulls the active-low tristate output low in the same cycle it asserts, with no register in that path. The output stays low for as long as the fault lasts. Once the fault clears, it stays low for a further programmable number of time-base ticks and is then released. The time base arrives as a single-cycle tick-enable input, one tick for each unit of the constant, where one unit is roughly 0.083 ms.

The hold constant is 16 bits wide and is written through a byte-wide register port, one byte at a time. A read-only status byte gathers the detector inputs. Each fault and warning bit reads 1 in normal operation and 0 when its condition is present. The PLL-unlock bit is the exception and reads 1 when the PLL is not locked.

Top module: `fault_hold_timer`

## Requirements
- R1: After reset, address 0x2B (constant upper byte) reads 0x00, address 0x2C (constant lower byte) reads 0x0C, and `tristate_n` is high while `fault_in` is low.
- R2: A write cycle (`wr_en` high) to 0x2B or 0x2C updates that byte at the clock edge, and the new value is readable in the following cycle. `rd_data` is combinational on `addr`.
- R3: In any cycle where `fault_in` is high, `tristate_n` is low in that same cycle.
- R4: Let N be the constant held when the fault ends. Counting from the first cycle in which `fault_in` is low, `tristate_n` stays low and returns high in the cycle after the N-th cycle in which `tick` is high.
- R5: Ticks that arrive while `fault_in` is high do not count toward the hold, because the count reloads from the constant on every such cycle.
- R6: A write to the constant while a recovery is counting leaves that recovery's duration unchanged. The new value is used by the next fault.
- R7: A constant of 0x0000 releases `tristate_n` in the first cycle after the first cycle in which `fault_in` is low, whatever `tick` does.
- R8: Address 0x2D reads, from bit 7 down to bit 0: `pll_unlock`, then the inverses of `fault_in`, `uv_det`, `ov_det`, `oc_det`, `ocw_det`, `tf_det` and `tw_det`.
- R9: Writes to 0x2D or to any unmapped address do not change the constant bytes. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Single-cycle time-base enable |
| fault_in | input | 1 | Power bridge fault, active high |
| pll_unlock | input | 1 | PLL not locked, active high |
| uv_det | input | 1 | Undervoltage detected |
| ov_det | input | 1 | Overvoltage detected |
| oc_det | input | 1 | Overcurrent fault detected |
| ocw_det | input | 1 | Overcurrent warning |
| tf_det | input | 1 | Thermal fault |
| tw_det | input | 1 | Thermal warning |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| tristate_n | output | 1 | Output stage enable, low forces tristate |

## Verification
The bench sweeps small constants, including zero and one, under random tick patterns. It checks the release cycle exactly against an independent count of ticks. An off-by-one in the terminal count shows up as a release one cycle early or late, and a design that lets ticks count during the fault releases too soon after a long fault. Bytes are rewritten partway through a recovery to catch a design that reloads the live count from the registers. Random detector vectors test every status bit for position and polarity, which exposes a swapped bit or an inverted PLL-unlock. Writes to the status address and to unmapped addresses confirm that the constant survives them.

// File: rtl/fault_hold_timer.sv
module fault_hold_timer #(
  parameter int          CW          = 16,
  parameter logic [7:0]  A_HI        = 8'h2B,
  parameter logic [7:0]  A_LO        = 8'h2C,
  parameter logic [7:0]  A_STAT      = 8'h2D,
  parameter logic [CW-1:0] RST_CONST = 16'h000C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fault_in,
  input  logic       pll_unlock,
  input  logic       uv_det,
  input  logic       ov_det,
  input  logic       oc_det,
  input  logic       ocw_det,
  input  logic       tf_det,
  input  logic       tw_det,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       tristate_n
);
  localparam int HW = CW - 8;

  logic [HW-1:0] const_hi;
  logic [7:0]    const_lo;
  logic [CW-1:0] hold_const;
  logic [CW-1:0] count;
  logic          holding;
  logic [7:0]    status;

  assign hold_const = {const_hi, const_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      const_hi <= RST_CONST[CW-1:8];
      const_lo <= RST_CONST[7:0];
    end else if (wr_en) begin
      if (addr == A_HI) const_hi <= wr_data[HW-1:0];
      if (addr == A_LO) const_lo <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holding <= 1'b0;
      count   <= '0;
    end else if (fault_in) begin
      holding <= 1'b1;
      count   <= hold_const;
    end else if (holding) begin
      if (count == '0) begin
        holding <= 1'b0;
      end else if (tick) begin
        count <= count - 1'b1;
        if (count == {{(CW-1){1'b0}}, 1'b1}) holding <= 1'b0;
      end
    end
  end

  assign tristate_n = !(fault_in || holding);

  assign status = {pll_unlock, ~fault_in, ~uv_det, ~ov_det,
                   ~oc_det, ~ocw_det, ~tf_det, ~tw_det};

  always_comb begin
    rd_data = 8'h00;
    if (addr == A_HI)        rd_data = 8'(const_hi);
    else if (addr == A_LO)   rd_data = const_lo;
    else if (addr == A_STAT) rd_data = status;
  end

  p_low_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |-> !tristate_n);

  p_reload_in_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> (holding && count == $past(hold_const)));

  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !fault_in && !tick) |=> $stable(count));

  p_release_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tristate_n) |-> ($past(count) <= {{(CW-1){1'b0}}, 1'b1}));

  p_count_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !fault_in) |=>
      (count == $past(count) || count == $past(count) - 1'b1));

  p_const_protected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (addr != A_HI && addr != A_LO)) |=> $stable(hold_const));
endmodule

// File: tb/fault_hold_timer_tb.sv
module fault_hold_timer_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, fault_in = 0;
  logic pll_unlock = 0, uv_det = 0, ov_det = 0, oc_det = 0, ocw_det = 0, tf_det = 0, tw_det = 0;
  logic wr_en = 0;
  logic [7:0] addr = 0, wr_data = 0, rd_data;
  logic tristate_n;
  int n_run = 0, n_fail = 0;
  logic [15:0] mconst = 16'h000C;

  always #2 clk = ~clk;

  fault_hold_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_in(fault_in),
    .pll_unlock(pll_unlock), .uv_det(uv_det), .ov_det(ov_det), .oc_det(oc_det),
    .ocw_det(ocw_det), .tf_det(tf_det), .tw_det(tw_det),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .tristate_n(tristate_n));

  function automatic logic [7:0] exp_status(logic [6:0] det, logic pu);
    return {pu, ~det};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic next();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    next();
    wr_en = 0;
    if (a == 8'h2B) mconst[15:8] = d;
    if (a == 8'h2C) mconst[7:0] = d;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] expv);
    addr = a;
    @(negedge clk);
    chk(req, {8'h00, rd_data}, {8'h00, expv});
    next();
  endtask

  task automatic recovery(logic [15:0] n, int fcyc, int tick_mode, bit mid_write, logic [15:0] nv);
    int cnt;
    bit rel;
    wr(8'h2B, n[15:8]);
    wr(8'h2C, n[7:0]);
    fault_in = 1;
    for (int i = 0; i < fcyc; i++) begin
      tick = (tick_mode == 1) ? 1'b1 : 1'($urandom % 2);
      @(negedge clk);
      chk("R3", {15'd0, tristate_n}, 16'd0);
      next();
    end
    fault_in = 0;
    cnt = 0; rel = 0;
    for (int c = 0; c < 4 * n + 10; c++) begin
      tick = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? 1'b0 : 1'($urandom % 2);
      if (mid_write && c == 1) begin
        addr = (n[0]) ? 8'h2B : 8'h2C;
        wr_data = (n[0]) ? nv[15:8] : nv[7:0];
        wr_en = 1;
      end
      @(negedge clk);
      chk(n == 0 ? "R7" : (mid_write ? "R6" : (fcyc > 5 ? "R5" : "R4")),
          {15'd0, tristate_n}, {15'd0, rel});
      if (tick) cnt++;
      if (n == 0 || cnt >= n) rel = 1;
      next();
      if (wr_en) begin
        wr_en = 0;
        if (addr == 8'h2B) mconst[15:8] = wr_data;
        if (addr == 8'h2C) mconst[7:0] = wr_data;
      end
    end
    tick = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] det;
    logic [15:0] v;
    void'($urandom(32'd2024));
    #1;
    @(negedge clk);
    chk("R1", {15'd0, tristate_n}, 16'd1);
    next(); next();
    rst_n = 1;
    next();
    rd("R1", 8'h2B, 8'h00);
    rd("R1", 8'h2C, 8'h0C);
    @(negedge clk); chk("R1", {15'd0, tristate_n}, 16'd1); next();

    wr(8'h2B, 8'hA5); wr(8'h2C, 8'h3C);
    rd("R2", 8'h2B, 8'hA5);
    rd("R2", 8'h2C, 8'h3C);

    wr(8'h2D, 8'h00); wr(8'h50, 8'hFF); wr(8'h00, 8'h11);
    rd("R9", 8'h2B, 8'hA5);
    rd("R9", 8'h2C, 8'h3C);
    rd("R9", 8'h50, 8'h00);
    rd("R9", 8'hFF, 8'h00);

    for (int i = 0; i < 40; i++) begin
      det = 7'($urandom);
      pll_unlock = 1'($urandom);
      {uv_det, ov_det, oc_det, ocw_det, tf_det, tw_det} = det[5:0];
      fault_in = det[6];
      rd("R8", 8'h2D, exp_status(det, pll_unlock));
      fault_in = 0;
      next();
    end
    {pll_unlock, uv_det, ov_det, oc_det, ocw_det, tf_det, tw_det} = '0;

    recovery(16'd0, 3, 0, 0, 0);
    recovery(16'd0, 1, 2, 0, 0);
    recovery(16'd1, 2, 0, 0, 0);
    recovery(16'd1, 1, 1, 0, 0);
    recovery(16'd3, 30, 1, 0, 0);
    recovery(16'd5, 8, 2, 0, 0);
    recovery(16'd12, 4, 0, 1, 16'h0102);
    recovery(16'd2, 3, 0, 1, 16'h0000);

    for (int i = 0; i < 40; i++) begin
      v = 16'($urandom % 21);
      recovery(v, 1 + int'($urandom % 12), 0, ($urandom % 3) == 0, 16'($urandom));
      rd("R2", 8'h2B, mconst[15:8]);
      rd("R2", 8'h2C, mconst[7:0]);
    end

    wr(8'h2C, 8'h04); wr(8'h2B, 8'h00);
    wr(8'h2D, 8'hFF); wr(8'h7E, 8'h00);
    recovery(mconst, 2, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule